// File: doc/BRIEF.md
# Edge-Programmed Multichannel PWM Generator

This block drives sixteen pulse-width outputs from one shared time base. A prescaler divides the input clock. A period counter then steps once per prescaled tick and restarts after a programmable number of ticks. Each channel does not store a duty value. It holds two compare positions instead: a rise position that drives the output high and a fall position that drives it low. Firmware chooses where each edge lands inside the shared period. Equal positions give a toggle once per period. A position one beyond the last count never matches, which holds the output constant.

Software reaches the block through a plain byte-addressed register port. A write lands on the rising clock edge and the read data is combinational. Some channels are built with a second copy of their edge registers, selected by a parameter mask. While synchronous update is switched on, edge writes to those channels wait in that copy and move into the active compare registers only when the period counter restarts. A period that has already begun therefore always completes with the edge values it started with. The enables, prescaler and period are never held back, and neither is any channel built without the extra copy.

The register port carries no stream data, so it is a plain strobe interface with no back-pressure: a write is taken in every cycle `bus_we` is high.

Top module: `pwm_edge_bank`

## Requirements
- R1: The prescaler and period fields count one-based. With prescale value P and period value N, one period lasts exactly (P+1)*(N+1) input clocks, and consecutive rising edges of a running channel are that many clocks apart.
- R2: Register byte addresses, all 8 bits wide, with bits [1:0] required to be zero: prescale 0x00, period 0x04, enables 0x08 (bit b controls channel b) and 0x0C (bit b controls channel 8+b), rise position of channel i at 0x10+8*i, fall position at 0x14+8*i, sync-update switch bit 0 at 0xE4. Every one reads back what was last written to it, except the edge registers (see R7). Writes to other or misaligned addresses are ignored and such reads return 0.
- R3: On each prescaled tick, an enabled channel goes high when the count equals its rise position and low when it equals its fall position. With distinct positions r and f, both at most N, the output is high for ((f-r) mod (N+1))*(P+1) clocks of every period.
- R4: When a channel's rise and fall positions are equal and at most N, its output inverts once per period, giving a 50% waveform whose period is twice the counter period.
- R5: A position of N+1 is never reached. Rise at N+1 keeps an enabled channel low, and fall at N+1 with a reachable rise keeps it high.
- R6: A channel whose enable bit is 0 drives 0 from the clock after the bit clears. Enable writes are never deferred.
- R7: With sync update on (0xE4 bit 0 = 1), edge writes to a channel built with shadow copies are held back. They become active at the next period counter restart, and reads of the edge register return the active value until then.
- R8: Edge writes take effect and read back on the next clock on a channel built without shadow copies (any sync setting), and on any channel while sync update is off.
- R9: After reset every register reads 0, all outputs are 0 and sync update is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 8 | Byte address for both read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pwm_out | output | 16 | One waveform output per channel |

## Verification
A prescaler or period counter that is off by one shows up at every output as a period that is too long or too short, within the first full period. A compare register holding a wrong value changes the high time of its channel in the very next period. A shadow copy that loads at the wrong moment shows through the edge register read port: the value appears early, within the same period as the write, or it does not appear after the counter restarts. A stuck toggle or enable state shows as a constant output over a two-period window.

// File: rtl/pwm_edge_pkg.sv
`timescale 1ns/1ps
package pwm_edge_pkg;

  // Byte offsets of the register file; decode depends on these.
  localparam int unsigned OFS_PRESCALE  = 32'h00;
  localparam int unsigned OFS_PERIOD    = 32'h04;
  localparam int unsigned OFS_ENABLE    = 32'h08;
  localparam int unsigned OFS_EDGE      = 32'h10;
  localparam int unsigned OFS_SYNC      = 32'hE4;

  localparam int unsigned ENABLE_STRIDE = 4;  // one enable byte per word
  localparam int unsigned ENABLE_BITS   = 8;  // channels per enable byte
  localparam int unsigned EDGE_STRIDE   = 8;  // rise word then fall word

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRESCALE,
    RK_PERIOD,
    RK_ENABLE,
    RK_RISE,
    RK_FALL,
    RK_SYNC
  } reg_kind_e;

endpackage

// File: rtl/pwm_edge_decode.sv
`timescale 1ns/1ps
module pwm_edge_decode
  import pwm_edge_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 8,
  parameter int IW  = 4
) (
  input  logic [AW-1:0] addr,
  output reg_kind_e     kind,
  output logic [IW-1:0] idx
);

  localparam int unsigned EN_REGS  = (NCH + ENABLE_BITS - 1) / ENABLE_BITS;
  localparam int unsigned EN_END   = OFS_ENABLE + ENABLE_STRIDE * EN_REGS;
  localparam int unsigned EDGE_END = OFS_EDGE + EDGE_STRIDE * NCH;

  int unsigned a;

  always_comb begin
    a    = 32'(addr);
    kind = RK_NONE;
    idx  = '0;
    if (a[1:0] == 2'b00) begin
      if (a == OFS_PRESCALE) begin
        kind = RK_PRESCALE;
      end else if (a == OFS_PERIOD) begin
        kind = RK_PERIOD;
      end else if (a >= OFS_ENABLE && a < EN_END) begin
        kind = RK_ENABLE;
        idx  = IW'((a - OFS_ENABLE) / ENABLE_STRIDE);
      end else if (a >= OFS_EDGE && a < EDGE_END) begin
        kind = (((a - OFS_EDGE) % EDGE_STRIDE) == 0) ? RK_RISE : RK_FALL;
        idx  = IW'((a - OFS_EDGE) / EDGE_STRIDE);
      end else if (a == OFS_SYNC) begin
        kind = RK_SYNC;
      end
    end
  end

endmodule

// File: rtl/pwm_edge_timebase.sv
`timescale 1ns/1ps
module pwm_edge_timebase #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] prescale,
  input  logic [DW-1:0] period,
  output logic          tick,
  output logic          wrap,
  output logic [DW-1:0] count
);

  logic [DW-1:0] pre_q;
  logic [DW-1:0] cnt_q;

  // ">=" keeps both counters bounded if software shrinks a limit mid-run.
  assign tick  = (pre_q >= prescale);
  assign wrap  = tick && (cnt_q >= period);
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (wrap)      cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_PRESCALE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> pre_q == $past(pre_q) + 1'b1); // R1

  AST_PERIOD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0) && (pre_q == '0)); // R1

  AST_COUNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> cnt_q == $past(cnt_q) + 1'b1); // R1

endmodule

// File: rtl/pwm_edge_chan.sv
`timescale 1ns/1ps
module pwm_edge_chan #(
  parameter int DW       = 8,
  parameter bit SHADOWED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sync_on,
  input  logic          wr_rise,
  input  logic          wr_fall,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  input  logic          wrap,
  input  logic [DW-1:0] count,
  output logic [DW-1:0] rise_act,
  output logic [DW-1:0] fall_act,
  output logic          out
);

  logic [DW-1:0] rise_q;
  logic [DW-1:0] fall_q;
  logic          hit_r;
  logic          hit_f;

  generate
    if (SHADOWED) begin : g_shadow
      logic [DW-1:0] rise_sh;
      logic [DW-1:0] fall_sh;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rise_sh <= '0;
          fall_sh <= '0;
          rise_q  <= '0;
          fall_q  <= '0;
        end else begin
          if (wr_rise) rise_sh <= wdata;
          if (wr_fall) fall_sh <= wdata;
          if (!sync_on) begin
            if (wr_rise) rise_q <= wdata;
            if (wr_fall) fall_q <= wdata;
          end else if (wrap) begin
            rise_q <= rise_sh;
            fall_q <= fall_sh;
          end
        end
      end

      AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_on && !wrap) |=> $stable(rise_q) && $stable(fall_q)); // R7

    end else begin : g_direct

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rise_q <= '0;
          fall_q <= '0;
        end else begin
          if (wr_rise) rise_q <= wdata;
          if (wr_fall) fall_q <= wdata;
        end
      end

      AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rise |=> rise_q == $past(wdata)); // R8

    end
  endgenerate

  assign hit_r    = (count == rise_q);
  assign hit_f    = (count == fall_q);
  assign rise_act = rise_q;
  assign fall_act = fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out <= 1'b0;
    end else if (!en) begin
      out <= 1'b0;
    end else if (tick) begin
      if (hit_r && hit_f) out <= ~out;
      else if (hit_r)     out <= 1'b1;
      else if (hit_f)     out <= 1'b0;
    end
  end

  AST_EQUAL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && hit_r && hit_f) |=> out != $past(out)); // R4

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out); // R6

endmodule

// File: rtl/pwm_edge_bank.sv
`timescale 1ns/1ps
module pwm_edge_bank
  import pwm_edge_pkg::*;
#(
  parameter int             NCH         = 16,
  parameter int             DW          = 8,
  parameter int             AW          = 8,
  parameter logic [NCH-1:0] SHADOW_MASK = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);

  localparam int IW      = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int EN_REGS = (NCH + ENABLE_BITS - 1) / ENABLE_BITS;
  localparam int ENP     = EN_REGS * ENABLE_BITS;

  logic [DW-1:0]  prescale_q;
  logic [DW-1:0]  period_q;
  logic [NCH-1:0] en_q;
  logic           sync_q;
  logic [ENP-1:0] en_pad;

  reg_kind_e      kind;
  logic [IW-1:0]  idx;

  logic           tick;
  logic           wrap;
  logic [DW-1:0]  count;

  logic [DW-1:0]  rise_act [NCH];
  logic [DW-1:0]  fall_act [NCH];

  pwm_edge_decode #(.NCH(NCH), .AW(AW), .IW(IW)) u_decode (
    .addr (bus_addr),
    .kind (kind),
    .idx  (idx)
  );

  pwm_edge_timebase #(.DW(DW)) u_timebase (
    .clk      (clk),
    .rst_n    (rst_n),
    .prescale (prescale_q),
    .period   (period_q),
    .tick     (tick),
    .wrap     (wrap),
    .count    (count)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chan
      logic wr_r;
      logic wr_f;
      assign wr_r = bus_we && (kind == RK_RISE) && (idx == IW'(i));
      assign wr_f = bus_we && (kind == RK_FALL) && (idx == IW'(i));

      pwm_edge_chan #(.DW(DW), .SHADOWED(SHADOW_MASK[i])) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q[i]),
        .sync_on  (sync_q),
        .wr_rise  (wr_r),
        .wr_fall  (wr_f),
        .wdata    (bus_wdata),
        .tick     (tick),
        .wrap     (wrap),
        .count    (count),
        .rise_act (rise_act[i]),
        .fall_act (fall_act[i]),
        .out      (pwm_out[i])
      );
    end
  endgenerate

  // Control registers: never shadowed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescale_q <= '0;
      period_q   <= '0;
      en_q       <= '0;
      sync_q     <= 1'b0;
    end else if (bus_we) begin
      case (kind)
        RK_PRESCALE: prescale_q <= bus_wdata;
        RK_PERIOD:   period_q   <= bus_wdata;
        RK_SYNC:     sync_q     <= bus_wdata[0];
        RK_ENABLE: begin
          for (int i = 0; i < NCH; i++) begin
            if ((i / ENABLE_BITS) == int'(idx)) en_q[i] <= bus_wdata[i % ENABLE_BITS];
          end
        end
        default: ;
      endcase
    end
  end

  assign en_pad = ENP'(en_q);

  always_comb begin
    bus_rdata = '0;
    case (kind)
      RK_PRESCALE: bus_rdata = prescale_q;
      RK_PERIOD:   bus_rdata = period_q;
      RK_SYNC:     bus_rdata = DW'(sync_q);
      RK_ENABLE:   bus_rdata = DW'(en_pad[idx*ENABLE_BITS +: ENABLE_BITS]);
      RK_RISE:     bus_rdata = rise_act[idx];
      RK_FALL:     bus_rdata = fall_act[idx];
      default:     bus_rdata = '0;
    endcase
  end

endmodule

// File: tb/sim_pwm_edge_bank.sv
`timescale 1ns/1ps
module sim_pwm_edge_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [15:0] pwm_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int hc [16];

  always #2.5 clk = ~clk;

  pwm_edge_bank #(.SHADOW_MASK(16'h00FF)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we    = 1'b1;
    bus_addr  = 8'(a);
    bus_wdata = 8'(d);
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = 8'(a);
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic set_edges(input int ch, input int r, input int f);
    wr(16 + 8 * ch, r);
    wr(20 + 8 * ch, f);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int cycles);
    for (int c = 0; c < 16; c++) hc[c] = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      for (int c = 0; c < 16; c++) hc[c] += int'(pwm_out[c]);
    end
  endtask

  task automatic wait_rise(input int ch, output int cycles);
    int prev;
    prev = int'(pwm_out[ch]);
    cycles = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      cycles++;
      if (prev == 0 && pwm_out[ch] == 1'b1) break;
      prev = int'(pwm_out[ch]);
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    int t;
    int exp;
    int c;
    int sweep_ch [4] = '{0, 1, 8, 9};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    rd(8'h00, v); chk("R9 prescale after reset", v, 0);
    rd(8'h04, v); chk("R9 period after reset", v, 0);
    rd(8'h08, v); chk("R9 enable low after reset", v, 0);
    rd(8'h0C, v); chk("R9 enable high after reset", v, 0);
    rd(8'hE4, v); chk("R9 sync off after reset", v, 0);
    rd(8'h10, v); chk("R9 rise ch0 after reset", v, 0);
    rd(8'h8C, v); chk("R9 fall ch15 after reset", v, 0);
    idle(10);
    chk("R9 outputs after reset", int'(pwm_out), 0);

    // R2: register map and readback
    wr(8'h00, 8'h5A); rd(8'h00, v); chk("R2 prescale readback", v, 8'h5A);
    wr(8'h04, 8'hA5); rd(8'h04, v); chk("R2 period readback", v, 8'hA5);
    wr(8'h0C, 8'hC3); rd(8'h0C, v); chk("R2 enable high readback", v, 8'hC3);
    rd(8'h08, v); chk("R2 enable low untouched", v, 0);
    wr(8'h0C, 8'h00);
    wr(8'h11, 8'h77); rd(8'h10, v); chk("R2 misaligned write ignored", v, 0);
    rd(8'h11, v); chk("R2 misaligned read zero", v, 0);
    wr(8'h90, 8'h33); rd(8'h90, v); chk("R2 unmapped read zero", v, 0);
    wr(8'h8C, 8'h21); rd(8'h8C, v); chk("R2 fall ch15 readback", v, 8'h21);
    wr(8'h8C, 8'h00);

    // R3 / R4 sweep over all edge pairs on four channels
    wr(8'h08, 8'h03);
    wr(8'h0C, 8'h03);
    for (int pi = 0; pi < 2; pi++) begin
      for (int ni = 0; ni < 2; ni++) begin
        int p;
        int n;
        p = 2 * pi;
        n = 3 + 2 * ni;
        t = (p + 1) * (n + 1);
        wr(8'h00, p);
        wr(8'h04, n);
        for (int r = 0; r <= n; r++) begin
          for (int f = 0; f <= n; f++) begin
            for (int k = 0; k < 4; k++) set_edges(sweep_ch[k], r, f);
            idle(2 * t);
            count_high(2 * t);
            if (r == f) exp = t;
            else exp = 2 * (((f - r + n + 1) % (n + 1)) * (p + 1));
            for (int k = 0; k < 4; k++) begin
              if (r == f) chk("R4 equal edges high time", hc[sweep_ch[k]], exp);
              else        chk("R3 edge positions high time", hc[sweep_ch[k]], exp);
            end
          end
        end
        chk("R6 disabled channel 2 stays low", hc[2], 0);
      end
    end

    // R5: unreachable positions hold the output
    wr(8'h00, 1);
    wr(8'h04, 3);
    set_edges(0, 4, 2);
    set_edges(1, 0, 4);
    set_edges(9, 0, 2);
    idle(16);
    count_high(16);
    chk("R5 rise unreachable stays low", hc[0], 0);
    chk("R5 fall unreachable stays high", hc[1], 16);

    // R6: enable cleared for channel 8 via the upper enable byte
    wr(8'h0C, 8'h02);
    idle(2);
    count_high(16);
    chk("R6 channel 8 disabled drives 0", hc[8], 0);
    chk("R6 channel 9 still running", hc[9], 8);

    // R1: period length = (P+1)*(N+1)
    wr(8'h00, 3);
    wr(8'h04, 4);
    idle(40);
    wait_rise(9, c);
    wait_rise(9, c);
    chk("R1 rise-to-rise spacing", c, 20);
    count_high(20);
    chk("R3 high time with prescale 3", hc[9], 8);

    // R7 / R8: shadow behaviour
    set_edges(0, 1, 3);
    wr(8'hE4, 1);
    rd(8'hE4, v); chk("R2 sync switch readback", v, 1);
    wait_rise(9, c);
    wr(8'h10, 2);
    wr(8'h50, 4);
    rd(8'h10, v); chk("R7 shadowed rise still old", v, 1);
    rd(8'h50, v); chk("R8 direct channel immediate", v, 4);
    idle(25);
    rd(8'h10, v); chk("R7 shadowed rise applied after restart", v, 2);
    wr(8'hE4, 0);
    wr(8'h14, 0);
    rd(8'h14, v); chk("R8 shadowed channel immediate with sync off", v, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule